// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block keeps the delivery state of up to 256 interrupt vectors, each named by an 8-bit number. Every vector holds two bits: a pending bit and an in-service bit. Together they encode four states. Inactive is 00. Pending is 10. Serviced with nothing waiting is 01. Serviced with one more arrival captured is 11.

A larger number means a higher priority. Bits [7:4] of a vector number are its priority class. The controller raises a request to the core when three things hold:

- some pending vector outranks every vector in service;
- the global enable is set;
- the task-priority mask does not cover that vector.

Software takes the best vector with an acquire read. It reports completion with an end-of-service write. Both strobes last one cycle and take effect at the rising clock edge. The acquire result `acq_vec` is combinational and is valid in the cycle of the read. When several events fall in the same cycle, the acquire and the end-of-service update are applied first, and the arrival is applied after them.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset makes every vector Inactive and disables the task-priority mask. Afterwards `irq` is 0 and `acq_vec` reads 15.
- R2: An arrival on an Inactive vector makes it Pending. An arrival on a vector that is already Pending changes nothing, so one acquire later removes it completely.
- R3: Arrivals on vectors 0 to 15 are ignored.
- R4: A vector is deliverable when three things hold: it is pending, its number is above the highest in-service vector (or nothing is in service), and the mask does not cover it. `irq` is 1 exactly when a deliverable vector exists and `gie` is 1.
- R5: When a deliverable vector exists, `acq_vec` shows the highest one, whatever the value of `gie`. An acquire read moves that vector to serviced-with-nothing-waiting. From then on it masks every vector with an equal or lower number.
- R6: When no vector is deliverable, `acq_vec` reads 15 and an acquire read changes no state.
- R7: An arrival on a vector that is serviced with nothing waiting captures exactly one extra arrival. Further arrivals on that vector are absorbed and not counted.
- R8: An end-of-service write acts on the highest in-service vector. Serviced-with-nothing-waiting goes to Inactive, and serviced-with-one-captured goes back to Pending. Lower vectors are unmasked again.
- R9: An end-of-service write made while no vector is in service is ignored.
- R10: A task-priority write loads the enable bit `tpr_en_in` and the 4-bit class `tpr_cls_in`. While the enable is set, every vector whose bits [7:4] are at most that class is masked. Masked vectors stay pending until they are unmasked.
- R11: An arrival on the vector being acquired in the same cycle is captured as its one extra arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gie | input | 1 | Global interrupt enable |
| arr_valid | input | 1 | An arrival is present this cycle |
| arr_vec | input | 8 | Vector number of the arrival |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_en_in | input | 1 | Mask enable bit to load |
| tpr_cls_in | input | 4 | Mask class to load |
| acq_rd | input | 1 | Acquire read strobe |
| acq_vec | output | 8 | Highest deliverable vector, or 15 |
| eoi_wr | input | 1 | End-of-service write strobe |
| irq | output | 1 | Interrupt request to the core |

## Verification
The assertions assume that each strobe is a single-cycle pulse sampled at the clock edge. They also assume that `arr_vec` matters only while `arr_valid` is high, and that reset is held high at time zero. The bench drives every input just after a falling edge, raises each strobe for exactly one cycle, and starts with reset asserted. Because of this, any change in `acq_vec` after an acquire can only come from the controller's own state update. The bench also keeps the number of vectors in service small, so every vector that goes into service is returned by an end-of-service write before the next sweep step begins.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int VW   = 8,
  parameter int CW   = 4,
  parameter int SPUR = 15,
  parameter int NRSV = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gie,
  input  logic          arr_valid,
  input  logic [VW-1:0] arr_vec,
  input  logic          tpr_we,
  input  logic          tpr_en_in,
  input  logic [CW-1:0] tpr_cls_in,
  input  logic          acq_rd,
  output logic [VW-1:0] acq_vec,
  input  logic          eoi_wr,
  output logic          irq
);
  localparam int NV = 1 << VW;

  logic [NV-1:0] pend, insv, pend_n, insv_n;
  logic          tpr_en;
  logic [CW-1:0] tpr_cls;

  logic          isv_hit, best_hit;
  logic [VW-1:0] isv_idx, best_idx;

  always_comb begin
    isv_hit = 1'b0;
    isv_idx = '0;
    for (int i = 0; i < NV; i++)
      if (insv[i]) begin
        isv_hit = 1'b1;
        isv_idx = VW'(i);
      end
  end

  always_comb begin
    logic [VW-1:0] iv;
    best_hit = 1'b0;
    best_idx = '0;
    for (int i = 0; i < NV; i++) begin
      iv = VW'(i);
      if (pend[i] && (!isv_hit || iv > isv_idx) &&
          !(tpr_en && iv[VW-1 -: CW] <= tpr_cls)) begin
        best_hit = 1'b1;
        best_idx = iv;
      end
    end
  end

  assign acq_vec = best_hit ? best_idx : VW'(SPUR);
  assign irq     = gie & best_hit;

  always_comb begin
    pend_n = pend;
    insv_n = insv;
    if (acq_rd && best_hit) begin
      pend_n[best_idx] = 1'b0;
      insv_n[best_idx] = 1'b1;
    end
    if (eoi_wr && isv_hit)
      insv_n[isv_idx] = 1'b0;
    if (arr_valid && int'(arr_vec) >= NRSV)
      pend_n[arr_vec] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= '0;
      insv    <= '0;
      tpr_en  <= 1'b0;
      tpr_cls <= '0;
    end else begin
      pend <= pend_n;
      insv <= insv_n;
      if (tpr_we) begin
        tpr_en  <= tpr_en_in;
        tpr_cls <= tpr_cls_in;
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int VW   = 8,
  parameter int SPUR = 15,
  parameter int NRSV = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               gie,
  input logic               arr_valid,
  input logic               acq_rd,
  input logic               eoi_wr,
  input logic [VW-1:0]      acq_vec,
  input logic               irq,
  input logic [(1<<VW)-1:0] pend,
  input logic [(1<<VW)-1:0] insv
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && acq_vec == VW'(SPUR)));

  // R4
  irq_needs_gie_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (gie && acq_vec != VW'(SPUR)));

  // R3
  no_reserved_out_chk: assert property (@(posedge clk) disable iff (rst)
    (acq_vec != VW'(SPUR)) |-> (int'(acq_vec) >= NRSV));

  // R5
  acquired_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (acq_rd && acq_vec != VW'(SPUR)) |=> (acq_vec != $past(acq_vec)));

  // R6
  spurious_still_chk: assert property (@(posedge clk) disable iff (rst)
    (acq_rd && acq_vec == VW'(SPUR) && !arr_valid && !eoi_wr)
      |=> ($stable(pend) && $stable(insv)));

  // R9
  idle_eoi_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_wr && insv == '0 && !acq_rd && !arr_valid)
      |=> ($stable(pend) && $stable(insv)));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.VW(VW), .SPUR(SPUR), .NRSV(NRSV)) u_chk (
  .clk(clk), .rst(rst), .gie(gie), .arr_valid(arr_valid), .acq_rd(acq_rd),
  .eoi_wr(eoi_wr), .acq_vec(acq_vec), .irq(irq), .pend(pend), .insv(insv)
);

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       gie = 1'b0, arr_valid = 1'b0, tpr_we = 1'b0, tpr_en_in = 1'b0;
  logic       acq_rd = 1'b0, eoi_wr = 1'b0;
  logic [7:0] arr_vec = '0;
  logic [3:0] tpr_cls_in = '0;
  logic [7:0] acq_vec;
  logic       irq;
  int applied = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rst(rst), .gie(gie), .arr_valid(arr_valid), .arr_vec(arr_vec),
    .tpr_we(tpr_we), .tpr_en_in(tpr_en_in), .tpr_cls_in(tpr_cls_in),
    .acq_rd(acq_rd), .acq_vec(acq_vec), .eoi_wr(eoi_wr), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic arrive(input int v);
    arr_valid = 1'b1; arr_vec = 8'(v);
    @(negedge clk);
    arr_valid = 1'b0;
  endtask

  task automatic acquire(input int exp, input string req);
    acq_rd = 1'b1;
    #1 chk(req, int'(acq_vec), exp);
    @(negedge clk);
    acq_rd = 1'b0;
  endtask

  task automatic eoi();
    eoi_wr = 1'b1;
    @(negedge clk);
    eoi_wr = 1'b0;
  endtask

  task automatic tpr(input bit en, input int c);
    tpr_we = 1'b1; tpr_en_in = en; tpr_cls_in = 4'(c);
    @(negedge clk);
    tpr_we = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    gie = 1'b1;
    #1 chk("R1 irq", int'(irq), 0);
    acquire(15, "R1 acq");

    for (int v = 16; v < 256; v++) begin
      arrive(v);
      #1 chk("R4 irq", int'(irq), 1);
      arrive(v);
      acquire(v, "R5");
      #1 chk("R4 irq off", int'(irq), 0);
      acquire(15, "R2 single");
      acquire(15, "R6");
      eoi();
      acquire(15, "R8 inactive");
    end

    for (int v = 0; v < 16; v++) begin
      arrive(v);
      #1 chk("R3 irq", int'(irq), 0);
      acquire(15, "R3");
    end

    arrive(100); acquire(100, "R7 first");
    arrive(100); arrive(100); arrive(100);
    acquire(15, "R7 masked self");
    eoi();
    #1 chk("R8 repend irq", int'(irq), 1);
    acquire(100, "R7 captured");
    eoi();
    acquire(15, "R7 absorbed");

    arrive(50); acquire(50, "R5 nest");
    arrive(40);
    #1 chk("R5 lower masked", int'(irq), 0);
    arrive(60);
    #1 chk("R4 higher", int'(irq), 1);
    acquire(60, "R5 higher");
    eoi();
    acquire(15, "R8 still masked");
    eoi();
    acquire(40, "R8 unmask");
    eoi();
    acquire(15, "R8 drained");

    arrive(80);
    eoi();
    acquire(80, "R9");
    eoi(); eoi();
    acquire(15, "R9 extra");

    gie = 1'b0;
    arrive(90);
    #1 chk("R4 gie", int'(irq), 0);
    acquire(90, "R5 gie");
    gie = 1'b1;
    eoi();

    arrive(20); arrive(200); arrive(130); arrive(77);
    acquire(200, "R5 order");
    acquire(15, "R5 order masked");
    eoi(); acquire(130, "R5 order");
    eoi(); acquire(77, "R5 order");
    eoi(); acquire(20, "R5 order");
    eoi(); acquire(15, "R5 order");

    arrive(120);
    arr_valid = 1'b1; arr_vec = 8'd120;
    acquire(120, "R11");
    arr_valid = 1'b0;
    acquire(15, "R11 held");
    eoi();
    acquire(120, "R11 captured");
    eoi();
    acquire(15, "R11 done");

    for (int c = 0; c < 16; c++) begin
      for (int k = 1; k < 16; k++) begin
        tpr(1'b1, c);
        arrive(k * 16 + 5);
        if (k > c) begin
          acquire(k * 16 + 5, "R10 open");
          eoi();
        end else begin
          #1 chk("R10 irq", int'(irq), 0);
          acquire(15, "R10 masked");
          tpr(1'b0, 0);
          acquire(k * 16 + 5, "R10 held");
          eoi();
        end
      end
    end
    tpr(1'b1, 3);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    arrive(20);
    acquire(20, "R1 mask off");
    eoi();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule